// File: doc/BRIEF.md
# IDLE Rate-Matching Controller

This block sits on the read side of four receive elastic buffers. It keeps them from overflowing or running dry when the lane clocks and the local read clock differ slightly. On each read cycle it looks at each buffer's fill level and at whether the character about to be read is an IDLE. From that it tells each lane to skip the IDLE (a deletion) or to read it twice (a duplication). The buffers and the character decoder are outside the block. They feed it fill levels and IDLE flags, and they carry out the commands in the same cycle.

The operating mode comes from two inputs: a lock input and a two-bit code that says what drives the sync input. The code is tied low, tied high, or driven from a sync output. The mode is one of three:
- Off.
- Independent: each lane rate-matches on its own.
- Aligned: the lanes are word-aligned and rate-match as one group. A deletion or duplication happens on every lane in the same cycle, and only when all lanes hold an IDLE. The lane furthest past a mark decides for the whole group.

A saturating per-lane count of deletions and duplications is brought out for observation.

Top module: `idle_rate_match`

## Requirements
- R1: With `lock_i`=0 and `sync_src_i`=2'b00 (sync tied low), `mode_o` is 2'b00 (off), `align_en_o` is 0 and no skip or repeat command is issued.
- R2: With `lock_i`=0 and `sync_src_i`=2'b01 (sync tied high), `mode_o` is 2'b01 (independent) and `align_en_o` is 0. Each lane's command depends only on that lane's fill level and IDLE flag.
- R3: With `lock_i`=0 and `sync_src_i[1]`=1 (sync driven from a sync output), `mode_o` is 2'b10 (aligned) and `align_en_o` is 1.
- R4: With `lock_i`=1, `mode_o` is 2'b00 and no command is issued, whatever the sync source. `align_en_o` equals `sync_src_i[1]`.
- R5: In aligned mode a command is issued only when every bit of `idle_i` is 1. When one is issued, it is issued on all lanes in the same cycle.
- R6: A lane whose `idle_i` bit is 0 never receives a skip or repeat command.
- R7: In independent mode a lane with a fill level above HI_MARK (default 6) gets `skip_o`. A lane below LO_MARK (default 2) gets `rept_o`. A lane with a fill level in [LO_MARK, HI_MARK] gets neither. No lane gets both in one cycle.
- R8: In aligned mode the group takes the highest fill level and computes its excess over HI_MARK. It also takes the lowest fill level and computes its shortfall under LO_MARK. The larger of the two nonzero values picks skip or repeat for all lanes. A tie picks skip.
- R9: Each lane has a skip counter and a repeat counter. Both are zero after reset. Each adds one at every clock edge on which that lane's command is high. Each holds at 2^CNT_W-1 once it gets there.
- R10: With `rd_en_i`=0 no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Lock mode; 1 disables rate matching |
| sync_src_i | input | 2 | Sync source: 00 tied low, 01 tied high, 1x from sync output |
| rd_en_i | input | 1 | A word is read this cycle |
| idle_i | input | NUM_LANES | Per-lane IDLE flag for the character at the read pointer |
| fill_i | input | NUM_LANES*FW | Per-lane buffer fill level, lane i at bits [i*FW +: FW] |
| mode_o | output | 2 | 00 off, 01 independent, 10 aligned |
| align_en_o | output | 1 | Word alignment enabled |
| skip_o | output | NUM_LANES | Per-lane command to delete the current IDLE |
| rept_o | output | NUM_LANES | Per-lane command to duplicate the current IDLE |
| skip_cnt_o | output | NUM_LANES*CNT_W | Per-lane saturating deletion counts |
| rept_cnt_o | output | NUM_LANES*CNT_W | Per-lane saturating duplication counts |

## Verification
The bench builds the block with four lanes, a depth of 8 and marks of 6 and 2, but narrows CNT_W to 3. The counters therefore reach their ceiling of 7 within a few dozen commands, and the saturation hold is exercised many times in a short run. Fill levels are drawn over the full range 0 to 8, so both marks, their exact boundary values, and aligned-mode ties between excess and shortfall all occur.

// File: rtl/rm_pkg.sv
package rm_pkg;
  typedef enum logic [1:0] {
    RM_OFF     = 2'b00,
    RM_INDEP   = 2'b01,
    RM_ALIGNED = 2'b10
  } rm_mode_e;

  // sync_src: 00 tied low, 01 tied high, 1x from a sync output
  function automatic logic src_is_driven(input logic [1:0] src);
    return src[1];
  endfunction

  function automatic rm_mode_e pick_mode(input logic lock, input logic [1:0] src);
    if (lock)                   return RM_OFF;
    else if (src_is_driven(src)) return RM_ALIGNED;
    else if (src[0])            return RM_INDEP;
    else                        return RM_OFF;
  endfunction
endpackage

// File: rtl/rm_mode_decode.sv
module rm_mode_decode
  import rm_pkg::*;
(
  input  logic       lock_i,
  input  logic [1:0] sync_src_i,
  output rm_mode_e   mode_o,
  output logic       align_en_o
);
  always_comb begin
    mode_o     = pick_mode(lock_i, sync_src_i);
    align_en_o = src_is_driven(sync_src_i);
  end

  always_comb begin
    if (mode_o == RM_ALIGNED)
      AST_ALIGNED_HAS_ALIGN: assert (align_en_o); // R3
  end
endmodule

// File: rtl/rm_lane_ctrl.sv
module rm_lane_ctrl #(
  parameter int FW      = 4,
  parameter int HI_MARK = 6,
  parameter int LO_MARK = 2
) (
  input  logic [FW-1:0] fill_i,
  output logic          over_o,
  output logic          under_o
);
  localparam logic [FW-1:0] HI_L = FW'(HI_MARK);
  localparam logic [FW-1:0] LO_L = FW'(LO_MARK);

  always_comb begin
    over_o  = fill_i > HI_L;
    under_o = fill_i < LO_L;
  end

  always_comb begin
    AST_NOT_BOTH_MARKS: assert (!(over_o && under_o)); // R7
  end
endmodule

// File: rtl/rm_group_arb.sv
module rm_group_arb #(
  parameter int NUM_LANES = 4,
  parameter int FW        = 4,
  parameter int HI_MARK   = 6,
  parameter int LO_MARK   = 2
) (
  input  logic [NUM_LANES*FW-1:0] fill_i,
  output logic                    grp_skip_o,
  output logic                    grp_rept_o
);
  localparam logic [FW-1:0] HI_L = FW'(HI_MARK);
  localparam logic [FW-1:0] LO_L = FW'(LO_MARK);

  logic [FW-1:0] max_fill, min_fill, excess, shortfall;

  always_comb begin
    max_fill = fill_i[FW-1:0];
    min_fill = fill_i[FW-1:0];
    for (int i = 1; i < NUM_LANES; i++) begin
      if (fill_i[i*FW +: FW] > max_fill) max_fill = fill_i[i*FW +: FW];
      if (fill_i[i*FW +: FW] < min_fill) min_fill = fill_i[i*FW +: FW];
    end
    excess     = (max_fill > HI_L) ? max_fill - HI_L : '0;
    shortfall  = (min_fill < LO_L) ? LO_L - min_fill : '0;
    grp_skip_o = (excess != '0) && (excess >= shortfall);
    grp_rept_o = (shortfall != '0) && (shortfall > excess);
  end

  always_comb begin
    AST_GROUP_ONE_CMD: assert (!(grp_skip_o && grp_rept_o)); // R8
  end
endmodule

// File: rtl/rm_sat_cnt.sv
module rm_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_o <= '0;
    else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_HOLDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o == TOP |=> cnt_o == TOP); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && cnt_o != TOP) |=> cnt_o == $past(cnt_o) + 1'b1); // R9
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_o)); // R9
endmodule

// File: rtl/idle_rate_match.sv
module idle_rate_match
  import rm_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DEPTH     = 8,
  parameter int HI_MARK   = 6,
  parameter int LO_MARK   = 2,
  parameter int CNT_W     = 8,
  localparam int FW       = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lock_i,
  input  logic [1:0]                 sync_src_i,
  input  logic                       rd_en_i,
  input  logic [NUM_LANES-1:0]       idle_i,
  input  logic [NUM_LANES*FW-1:0]    fill_i,
  output logic [1:0]                 mode_o,
  output logic                       align_en_o,
  output logic [NUM_LANES-1:0]       skip_o,
  output logic [NUM_LANES-1:0]       rept_o,
  output logic [NUM_LANES*CNT_W-1:0] skip_cnt_o,
  output logic [NUM_LANES*CNT_W-1:0] rept_cnt_o
);
  rm_mode_e             mode;
  logic [NUM_LANES-1:0] over, under;
  logic                 grp_skip, grp_rept, all_idle;

  rm_mode_decode u_mode (
    .lock_i     (lock_i),
    .sync_src_i (sync_src_i),
    .mode_o     (mode),
    .align_en_o (align_en_o)
  );

  rm_group_arb #(
    .NUM_LANES (NUM_LANES), .FW (FW), .HI_MARK (HI_MARK), .LO_MARK (LO_MARK)
  ) u_grp (
    .fill_i     (fill_i),
    .grp_skip_o (grp_skip),
    .grp_rept_o (grp_rept)
  );

  assign mode_o   = mode;
  assign all_idle = &idle_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    rm_lane_ctrl #(.FW (FW), .HI_MARK (HI_MARK), .LO_MARK (LO_MARK)) u_lane (
      .fill_i  (fill_i[g*FW +: FW]),
      .over_o  (over[g]),
      .under_o (under[g])
    );

    always_comb begin
      skip_o[g] = 1'b0;
      rept_o[g] = 1'b0;
      if (rd_en_i) begin
        unique case (mode)
          RM_INDEP: begin
            skip_o[g] = idle_i[g] && over[g];
            rept_o[g] = idle_i[g] && under[g];
          end
          RM_ALIGNED: begin
            skip_o[g] = all_idle && grp_skip;
            rept_o[g] = all_idle && grp_rept;
          end
          default: ;
        endcase
      end
    end

    rm_sat_cnt #(.W (CNT_W)) u_skip_cnt (
      .clk (clk), .rst_n (rst_n), .inc_i (skip_o[g]),
      .cnt_o (skip_cnt_o[g*CNT_W +: CNT_W])
    );
    rm_sat_cnt #(.W (CNT_W)) u_rept_cnt (
      .clk (clk), .rst_n (rst_n), .inc_i (rept_o[g]),
      .cnt_o (rept_cnt_o[g*CNT_W +: CNT_W])
    );
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_i && sync_src_i == 2'b00) |-> (skip_o == '0 && rept_o == '0)); // R1
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |-> (skip_o == '0 && rept_o == '0)); // R4
  AST_ALIGNED_UNISON: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_ALIGNED) |-> ((skip_o == '0 || &skip_o) && (rept_o == '0 || &rept_o))); // R5
  AST_NO_DATA_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((skip_o | rept_o) & ~idle_i) == '0); // R6
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_o & rept_o) == '0); // R7
  AST_NO_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> (skip_o == '0 && rept_o == '0)); // R10
endmodule

// File: tb/idle_rate_match_tb_top.sv
module idle_rate_match_tb_top;
  localparam int NL = 4, DEPTH = 8, HI = 6, LO = 2, CW = 3;
  localparam int FW = $clog2(DEPTH + 1);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lock = 1'b0, rd_en = 1'b0;
  logic [1:0] src = 2'b00;
  logic [NL-1:0] idle = '0;
  logic [NL*FW-1:0] fill = '0;
  logic [1:0] mode;
  logic align_en;
  logic [NL-1:0] skip, rept;
  logic [NL*CW-1:0] skip_cnt, rept_cnt;

  int n_chk = 0, n_fail = 0;
  int m_skip[NL], m_rept[NL];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  idle_rate_match #(.NUM_LANES(NL), .DEPTH(DEPTH), .HI_MARK(HI), .LO_MARK(LO), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lock_i(lock), .sync_src_i(src), .rd_en_i(rd_en),
    .idle_i(idle), .fill_i(fill), .mode_o(mode), .align_en_o(align_en),
    .skip_o(skip), .rept_o(rept), .skip_cnt_o(skip_cnt), .rept_cnt_o(rept_cnt));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_mode(input logic l, input logic [1:0] s);
    if (l) return 0;
    if (s[1]) return 2;
    return s[0] ? 1 : 0;
  endfunction

  // expected commands from the requirement text
  task automatic expect_cmds(output logic [NL-1:0] es, output logic [NL-1:0] er);
    int m = exp_mode(lock, src);
    int mx = 0, mn = DEPTH, ex, sh;
    es = '0; er = '0;
    if (!rd_en || m == 0) return;
    if (m == 1) begin
      for (int i = 0; i < NL; i++) begin
        int f = int'(fill[i*FW +: FW]);
        es[i] = idle[i] && f > HI;
        er[i] = idle[i] && f < LO;
      end
    end else begin
      for (int i = 0; i < NL; i++) begin
        int f = int'(fill[i*FW +: FW]);
        if (f > mx) mx = f;
        if (f < mn) mn = f;
      end
      ex = (mx > HI) ? mx - HI : 0;
      sh = (mn < LO) ? LO - mn : 0;
      if (idle == '1) begin
        if (ex > 0 && ex >= sh) es = '1;
        else if (sh > 0) er = '1;
      end
    end
  endtask

  function automatic string cmd_tag();
    int m = exp_mode(lock, src);
    if (!rd_en) return "R10";
    if (lock) return "R4";
    if (m == 0) return "R1";
    if (m == 1) return "R7";
    return "R8";
  endfunction

  task automatic step(input logic l, input logic [1:0] s, input logic rd,
                      input logic [NL-1:0] id, input logic [NL*FW-1:0] fl,
                      input string ovr_tag);
    logic [NL-1:0] es, er;
    string t;
    @(negedge clk);
    lock = l; src = s; rd_en = rd; idle = id; fill = fl;
    #1;
    expect_cmds(es, er);
    t = (ovr_tag != "") ? ovr_tag : cmd_tag();
    check(lock ? "R4 mode" : (src[1] ? "R3 mode" : (src[0] ? "R2 mode" : "R1 mode")),
          int'(mode), exp_mode(lock, src));
    check(lock ? "R4 align" : "R3 align", int'(align_en), int'(src[1]));
    check({t, " skip"}, int'(skip), int'(es));
    check({t, " rept"}, int'(rept), int'(er));
    for (int i = 0; i < NL; i++) begin
      if (es[i] && m_skip[i] < CMAX) m_skip[i]++;
      if (er[i] && m_rept[i] < CMAX) m_rept[i]++;
    end
    @(posedge clk); #1;
    for (int i = 0; i < NL; i++) begin
      check("R9 skip count", int'(skip_cnt[i*CW +: CW]), m_skip[i]);
      check("R9 rept count", int'(rept_cnt[i*CW +: CW]), m_rept[i]);
    end
  endtask

  function automatic logic [NL*FW-1:0] pack(input int a, input int b, input int c, input int d);
    return {FW'(d), FW'(c), FW'(b), FW'(a)};
  endfunction

  initial begin
    for (int i = 0; i < NL; i++) begin m_skip[i] = 0; m_rept[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NL; i++) begin
      check("R9 reset skip", int'(skip_cnt[i*CW +: CW]), 0);
      check("R9 reset rept", int'(rept_cnt[i*CW +: CW]), 0);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1: off mode ignores extreme fills
    step(1'b0, 2'b00, 1'b1, '1, pack(8, 0, 8, 0), "R1");
    // R2: independent lanes decide separately, boundary values 7/6/2/1
    step(1'b0, 2'b01, 1'b1, '1, pack(7, 6, 2, 1), "R2");
    // R7: exact marks give nothing
    step(1'b0, 2'b01, 1'b1, '1, pack(6, 2, 6, 2), "R7");
    // R6: non-IDLE lanes untouched in independent mode
    step(1'b0, 2'b01, 1'b1, 4'b0101, pack(8, 8, 0, 0), "R6");
    // R5: aligned, one lane not IDLE blocks group
    step(1'b0, 2'b10, 1'b1, 4'b1110, pack(8, 8, 8, 8), "R5");
    // R3/R8: aligned all IDLE, skip
    step(1'b0, 2'b11, 1'b1, '1, pack(7, 4, 4, 4), "R3");
    // R8: tie excess 2 vs shortfall 2 -> skip
    step(1'b0, 2'b10, 1'b1, '1, pack(8, 0, 4, 4), "R8");
    // R8: shortfall 2 beats excess 1 -> repeat
    step(1'b0, 2'b10, 1'b1, '1, pack(7, 0, 4, 4), "R8");
    // R4: lock with every source
    for (int s = 0; s < 4; s++) step(1'b1, 2'(s), 1'b1, '1, pack(8, 8, 8, 8), "R4");
    // R10: no read
    step(1'b0, 2'b01, 1'b0, '1, pack(8, 0, 8, 0), "R10");
    // R9: drive lane skips into saturation
    for (int k = 0; k < CMAX + 3; k++) step(1'b0, 2'b01, 1'b1, '1, pack(8, 0, 8, 0), "R9");

    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 600; n++) begin
      logic [NL-1:0] id;
      logic [NL*FW-1:0] fl;
      logic l = ($urandom_range(9, 0) == 0);
      logic [1:0] s = 2'($urandom_range(3, 0));
      logic rd = ($urandom_range(7, 0) != 0);
      id = ($urandom_range(1, 0) == 1) ? '1 : NL'($urandom);
      for (int i = 0; i < NL; i++) fl[i*FW +: FW] = FW'($urandom_range(DEPTH, 0));
      step(l, s, rd, id, fl, "");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule